// File: doc/BRIEF.md
# Receive FIFO with Trigger-Level Status

This block buffers received bytes for a serial controller. The byte deserialiser offers each finished byte on a push strobe, and the block keeps up to sixteen bytes in a circular store. The host takes them back in arrival order through a read strobe. The current occupancy is always visible. A data-full status flag tells the host that enough bytes are waiting. That flag is tied to a programmable trigger level, not to the store being completely full.

A control-register write carries a 2-bit trigger select and a flush bit. The trigger select picks one of four thresholds: 1, 4, 8 or 14 bytes. The flag is set by a push that brings the occupancy to or above the threshold. It is cleared by a pop that brings the occupancy below it. A receive interrupt follows the flag, gated by an interrupt-enable level. A receiver-enable level decides whether offered bytes are taken in at all.

Top module: `rx_trigger_fifo`

## Requirements
- R1: After reset the count is 0, the data-full flag and the interrupt are low, read data is 0x00, and the trigger level is 1 byte.
- R2: Bytes are returned in the order they were accepted. The store wraps around through all 16 entries. While a pop is requested, popData shows the oldest byte, and the count drops by one at the clock edge.
- R3: A control write with ctrlFlush high empties the store and clears the flag and the interrupt. A push or pop in that same cycle has no effect. A control write with ctrlFlush low leaves the contents unchanged.
- R4: A push is accepted only while the count is below 16. A byte offered when the store is full is dropped, and the count stays at 16.
- R5: While rxEnable is low, pushes are ignored and the count does not change.
- R6: A control write loads the trigger level from ctrlTrigSel with the encoding 0→1, 1→4, 2→8, 3→14. An accepted push whose resulting count is at or above the trigger level sets dataFull.
- R7: A pop whose resulting count is below the trigger level clears dataFull. Changing the trigger level alone does not change dataFull. A new level applies from the cycle after the write.
- R8: A read request while the store is empty returns 0x00 and changes no state.
- R9: rxIrq rises with an accepted push that reaches the trigger while rxIntEnable is high. rxIrq falls in the cycle after rxIntEnable goes low, or when dataFull clears. rxIrq is never high without dataFull.
- R10: An accepted push and a pop in the same cycle leave the count unchanged, and both bytes move. dataFull then equals (count ≥ trigger).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pushValid | input | 1 | A received byte is offered |
| pushData | input | DATA_W | Received byte |
| rxEnable | input | 1 | Receiver enable level |
| rxIntEnable | input | 1 | Receive interrupt enable level |
| popReq | input | 1 | Host read of the data register |
| popData | output | DATA_W | Oldest byte, or 0x00 when empty |
| ctrlWrite | input | 1 | Control register write strobe |
| ctrlTrigSel | input | 2 | Trigger select field of the control write |
| ctrlFlush | input | 1 | Flush bit of the control write |
| count | output | CNT_W | Current occupancy (0 to 16) |
| dataFull | output | 1 | Trigger-level status flag |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
A push from the receiver and a pop from the host can land in the same clock. This cycle is where the count arithmetic, the two pointers and the flag rule all interact. The bench issues simultaneous push and pop at mid occupancy, exactly at the trigger level, and with the store full (where the push must be refused while the pop proceeds). The bench also pairs a flush with a push in the same cycle. A queue-based reference model predicts the count, the flag, the interrupt and the returned byte. These predictions are compared after every clock edge.

// File: rtl/rxfifo_pkg.sv
package rxfifo_pkg;

  // Strobes issued by the control unit to the storage datapath.
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
    logic hasData;
  } fifoStrobes_t;

  // Encoded, non-linear trigger thresholds.
  function automatic int trigFromSel(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/rxfifo_ctrl.sv
module rxfifo_ctrl
  import rxfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pushValid,
  input  logic             rxEnable,
  input  logic             rxIntEnable,
  input  logic             popReq,
  input  logic             ctrlWrite,
  input  logic [1:0]       ctrlTrigSel,
  input  logic             ctrlFlush,
  output fifoStrobes_t     strobes,
  output logic [CNT_W-1:0] count,
  output logic             dataFull,
  output logic             rxIrq
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic [CNT_W-1:0] trigLevel;
  logic [CNT_W-1:0] nextCount;
  logic             doPush, doPop, doClear;
  logic             flagNext, irqNext, reachTrig;

  assign doClear = ctrlWrite && ctrlFlush;
  assign doPush  = pushValid && rxEnable && (count < FULL_CNT) && !doClear;
  assign doPop   = popReq && (count != '0) && !doClear;

  assign strobes.push    = doPush;
  assign strobes.pop     = doPop;
  assign strobes.clear   = doClear;
  assign strobes.hasData = (count != '0);

  always_comb begin
    nextCount = count;
    if (doPush) nextCount = nextCount + ONE_CNT;
    if (doPop)  nextCount = nextCount - ONE_CNT;
  end

  assign reachTrig = (nextCount >= trigLevel);

  always_comb begin
    flagNext = dataFull;
    if (doClear)               flagNext = 1'b0;
    else if (doPush && doPop)  flagNext = reachTrig;
    else if (doPush)           flagNext = dataFull | reachTrig;
    else if (doPop)            flagNext = dataFull & reachTrig;
  end

  always_comb begin
    irqNext = rxIrq;
    if (doPush && reachTrig) irqNext = 1'b1;
    if (doClear || !rxIntEnable || !flagNext) irqNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= '0;
      dataFull  <= 1'b0;
      rxIrq     <= 1'b0;
      trigLevel <= ONE_CNT;
    end else begin
      count    <= doClear ? '0 : nextCount;
      dataFull <= flagNext;
      rxIrq    <= irqNext;
      if (ctrlWrite) trigLevel <= CNT_W'(trigFromSel(ctrlTrigSel));
    end
  end

endmodule

// File: rtl/rxfifo_store.sv
module rxfifo_store
  import rxfifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fifoStrobes_t      strobes,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] popData
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  headPtr, tailPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else if (strobes.clear) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      if (strobes.push) headPtr <= bump(headPtr);
      if (strobes.pop)  tailPtr <= bump(tailPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.push) mem[headPtr] <= pushData;
  end

  assign popData = strobes.hasData ? mem[tailPtr] : '0;

endmodule

// File: rtl/rx_trigger_fifo.sv
module rx_trigger_fifo
  import rxfifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              rxEnable,
  input  logic              rxIntEnable,
  input  logic              popReq,
  output logic [DATA_W-1:0] popData,
  input  logic              ctrlWrite,
  input  logic [1:0]        ctrlTrigSel,
  input  logic              ctrlFlush,
  output logic [CNT_W-1:0]  count,
  output logic              dataFull,
  output logic              rxIrq
);

  fifoStrobes_t strobes;

  rxfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .pushValid   (pushValid),
    .rxEnable    (rxEnable),
    .rxIntEnable (rxIntEnable),
    .popReq      (popReq),
    .ctrlWrite   (ctrlWrite),
    .ctrlTrigSel (ctrlTrigSel),
    .ctrlFlush   (ctrlFlush),
    .strobes     (strobes),
    .count       (count),
    .dataFull    (dataFull),
    .rxIrq       (rxIrq)
  );

  rxfifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .pushData (pushData),
    .popData  (popData)
  );

endmodule

// File: rtl/rx_trigger_fifo_chk.sv
module rx_trigger_fifo_chk #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pushValid,
  input logic              rxEnable,
  input logic              rxIntEnable,
  input logic              popReq,
  input logic              ctrlWrite,
  input logic              ctrlFlush,
  input logic [CNT_W-1:0]  count,
  input logic              dataFull,
  input logic              rxIrq,
  input logic [DATA_W-1:0] popData
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_CNT && pushValid && !popReq && !(ctrlWrite && ctrlFlush))
    |=> (count == FULL_CNT));

  p_flush_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlWrite && ctrlFlush) |=> (count == '0 && !dataFull && !rxIrq));

  p_disabled_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pushValid && !rxEnable && !popReq && !ctrlWrite) |=> $stable(count));

  p_empty_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (popData == '0));

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rxIrq |-> dataFull);

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rxIntEnable |=> !rxIrq);

  p_same_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pushValid && rxEnable && popReq && count != '0 && count != FULL_CNT &&
     !ctrlWrite) |=> $stable(count));

endmodule

bind rx_trigger_fifo rx_trigger_fifo_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pushValid   (pushValid),
  .rxEnable    (rxEnable),
  .rxIntEnable (rxIntEnable),
  .popReq      (popReq),
  .ctrlWrite   (ctrlWrite),
  .ctrlFlush   (ctrlFlush),
  .count       (count),
  .dataFull    (dataFull),
  .rxIrq       (rxIrq),
  .popData     (popData)
);

// File: tb/rx_trigger_fifo_bench.sv
module rx_trigger_fifo_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pushValid, rxEnable, rxIntEnable, popReq;
  logic       ctrlWrite, ctrlFlush;
  logic [1:0] ctrlTrigSel;
  logic [7:0] pushData, popData;
  logic [4:0] count;
  logic       dataFull, rxIrq;

  int checks = 0;
  int fails  = 0;

  logic [7:0] mq[$];
  int mTrig = 1;
  bit mFlag = 0;
  bit mIrq  = 0;

  always #5 clk = ~clk;

  rx_trigger_fifo u_rx_trigger_fifo (
    .clk(clk), .rst_n(rst_n), .pushValid(pushValid), .pushData(pushData),
    .rxEnable(rxEnable), .rxIntEnable(rxIntEnable), .popReq(popReq),
    .popData(popData), .ctrlWrite(ctrlWrite), .ctrlTrigSel(ctrlTrigSel),
    .ctrlFlush(ctrlFlush), .count(count), .dataFull(dataFull), .rxIrq(rxIrq)
  );

  function automatic int selToTrig(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    int expData;
    expData = (mq.size() > 0) ? int'(mq[0]) : 0;
    chk(int'(count) == mq.size(), tag, "count", int'(count), mq.size());
    chk(dataFull == mFlag, tag, "dataFull", int'(dataFull), int'(mFlag));
    chk(rxIrq == mIrq, tag, "rxIrq", int'(rxIrq), int'(mIrq));
    chk(int'(popData) == expData, tag, "popData", int'(popData), expData);
  endtask

  // One clock: predict from the reference model, advance, compare.
  task automatic cyc(input string tag);
    int c, n;
    bit clr, acc, dp, nf, ni, reach;
    logic [7:0] d;
    c   = mq.size();
    d   = pushData;
    clr = ctrlWrite && ctrlFlush;
    acc = pushValid && rxEnable && (c < 16) && !clr;
    dp  = popReq && (c > 0) && !clr;
    if (popReq && c > 0)
      chk(popData == mq[0], tag, "popData before pop", int'(popData), int'(mq[0]));
    n = c + int'(acc) - int'(dp);
    reach = (n >= mTrig);
    nf = mFlag;
    if (clr) nf = 0;
    else if (acc && dp) nf = reach;
    else if (acc && reach) nf = 1;
    else if (dp && !reach) nf = 0;
    ni = mIrq;
    if (acc && reach) ni = 1;
    if (clr || !rxIntEnable || !nf) ni = 0;
    @(posedge clk);
    @(negedge clk);
    if (clr) mq.delete();
    else begin
      if (dp) void'(mq.pop_front());
      if (acc) mq.push_back(d);
    end
    if (ctrlWrite) mTrig = selToTrig(ctrlTrigSel);
    mFlag = nf;
    mIrq  = ni;
    pushValid = 0; popReq = 0; ctrlWrite = 0; ctrlFlush = 0;
    compareAll(tag);
  endtask

  task automatic doPush(input logic [7:0] d, input string tag);
    pushValid = 1; pushData = d; cyc(tag);
  endtask

  task automatic doPop(input string tag);
    popReq = 1; cyc(tag);
  endtask

  task automatic doBoth(input logic [7:0] d, input string tag);
    pushValid = 1; pushData = d; popReq = 1; cyc(tag);
  endtask

  task automatic doCtl(input logic [1:0] sel, input bit fl, input string tag);
    ctrlWrite = 1; ctrlTrigSel = sel; ctrlFlush = fl; cyc(tag);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; pushValid = 0; pushData = 0; rxEnable = 0; rxIntEnable = 0;
    popReq = 0; ctrlWrite = 0; ctrlTrigSel = 0; ctrlFlush = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compareAll("R1");

    // Default trigger of 1: first byte sets the flag (R1, R6).
    rxEnable = 1;
    doPush(8'hA1, "R1");
    doPush(8'hA2, "R2");
    doPush(8'hA3, "R2");
    for (int i = 0; i < 3; i++) doPop("R2");
    doPop("R8");
    doPop("R8");

    // Receiver disabled: offered bytes ignored (R5).
    rxEnable = 0;
    doPush(8'h55, "R5");
    doPush(8'h56, "R5");
    rxEnable = 1;

    // Trigger 4 with interrupt enabled (R6, R9, R7).
    rxIntEnable = 1;
    doCtl(2'd1, 0, "R6");
    for (int i = 0; i < 4; i++) doPush(8'h20 + 8'(i), "R6");
    doPop("R7");
    doPush(8'h30, "R9");
    rxIntEnable = 0;
    cyc("R9");
    rxIntEnable = 1;

    // Raising the trigger alone keeps the flag; a pop below clears it (R7).
    doCtl(2'd3, 0, "R7");
    doPop("R7");

    // Fill to 16, then overflow attempts (R4).
    for (int i = 0; i < 13; i++) doPush(8'h40 + 8'(i), "R4");
    doPush(8'hEE, "R4");
    doPush(8'hEF, "R4");
    doBoth(8'hDD, "R10");
    for (int i = 0; i < 15; i++) doPop("R2");

    // Simultaneous push and pop, trigger 8 (R10).
    doCtl(2'd2, 0, "R10");
    for (int i = 0; i < 5; i++) doPush(8'h60 + 8'(i), "R10");
    for (int i = 0; i < 6; i++) doBoth(8'h70 + 8'(i), "R10");
    for (int i = 0; i < 3; i++) doPush(8'h80 + 8'(i), "R6");
    doBoth(8'h90, "R10");
    doPop("R7");

    // Flush, including a push in the same cycle (R3).
    doCtl(2'd2, 0, "R3");
    doCtl(2'd0, 1, "R3");
    doPush(8'hB1, "R3");
    doPush(8'hB2, "R3");
    pushValid = 1; pushData = 8'hB3; ctrlWrite = 1; ctrlTrigSel = 2'd0; ctrlFlush = 1;
    cyc("R3");
    doPush(8'hC1, "R3");
    doPop("R2");

    summary();
    $finish;
  end

endmodule